// File: doc/BRIEF.md
# Axis Status Flag Register

This block holds the eight-bit status byte for one axis of a 24-bit up/down position counter. The counter core sends it one-cycle strobes for underflow, overflow and noise errors. It also sends levels for the compare match, the count direction and the index input. The block turns these into a byte that the bus can read back.

The borrow, carry and compare bits do not latch. Each one inverts on its event, so software can detect that an event happened by comparing two reads. The sign bit follows the most recent wrap: underflow sets it and overflow clears it. The noise-error bit is sticky and is cleared only by its own command strobe. A second command strobe clears the three toggle bits and the sign bit together.

All bits are registered, so each flag reflects its inputs one clock after they are sampled. A synchronous reset clears the whole byte.

Top module: `axis_status_flags`

## Requirements
- R1: While `rst` is high at a rising clock edge, all eight flag bits are 0 after that edge.
- R2: Bit 0 (borrow toggle) inverts after every clock in which `ev_underflow` is 1.
- R3: Bit 1 (carry toggle) inverts after every clock in which `ev_overflow` is 1.
- R4: Bit 2 (compare toggle) inverts only after a clock in which `cmp_equal` is 1 and was 0 in the previous clock. It keeps its value while `cmp_equal` stays high. The previous-cycle value of `cmp_equal` is tracked during reset as well.
- R5: Bit 3 (sign) becomes 1 after an underflow and 0 after an overflow. If both arrive in the same clock, underflow wins and the bit becomes 1.
- R6: Bit 4 (error) becomes 1 after a clock with `ev_noise`=1 and `quad_mode`=1. With `quad_mode`=0 the noise strobe is ignored. Once set, the bit stays 1 until `clr_error` or reset.
- R7: Bit 5 equals `dir_up` and bit 6 equals `index_active` as sampled at the previous clock. Bit 7 always reads 0.
- R8: `clr_toggles` clears bits 0 to 3 at the next clock. It overrides any event on those bits in the same clock and leaves bits 4 to 6 unaffected.
- R9: `clr_error` clears bit 4 at the next clock. It overrides a noise strobe in the same clock and leaves the other bits unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ev_underflow | input | 1 | Counter underflow strobe |
| ev_overflow | input | 1 | Counter overflow strobe |
| cmp_equal | input | 1 | Preset equals counter, level |
| dir_up | input | 1 | Count direction, 1 = up |
| quad_mode | input | 1 | Quadrature mode enable |
| ev_noise | input | 1 | Noise pulse passed the input filter |
| index_active | input | 1 | Selected index input at its active level |
| clr_toggles | input | 1 | Command: clear toggle and sign bits |
| clr_error | input | 1 | Command: clear the error bit |
| flags | output | 8 | Status byte {0, idx, up, err, sign, cmp, carry, borrow} |

## Verification
The hardest situations to reach are collisions: a clear command in the same cycle as the event it targets, and a compare level that stays high across a clear or a reset. The directed stimulus builds these explicitly. It drives an underflow, an overflow and a fresh compare edge together with `clr_toggles`, and a noise strobe together with `clr_error`. It also holds `cmp_equal` high through reset and through several later cycles, which confirms that the level produces no extra toggles.

// File: rtl/axis_status_flags.sv
module axis_status_flags (
  input  logic       clk,
  input  logic       rst,
  input  logic       ev_underflow,
  input  logic       ev_overflow,
  input  logic       cmp_equal,
  input  logic       dir_up,
  input  logic       quad_mode,
  input  logic       ev_noise,
  input  logic       index_active,
  input  logic       clr_toggles,
  input  logic       clr_error,
  output logic [7:0] flags
);

  logic borrow_t, carry_t, cmp_t, sign_f, err_f, up_f, idx_f;
  logic eq_prev;
  logic cmp_edge;

  assign cmp_edge = cmp_equal & ~eq_prev;

  always_ff @(posedge clk) begin
    eq_prev <= cmp_equal;
    if (rst) begin
      borrow_t <= 1'b0;
      carry_t  <= 1'b0;
      cmp_t    <= 1'b0;
      sign_f   <= 1'b0;
      err_f    <= 1'b0;
      up_f     <= 1'b0;
      idx_f    <= 1'b0;
    end else begin
      up_f  <= dir_up;
      idx_f <= index_active;
      if (clr_toggles) begin
        borrow_t <= 1'b0;
        carry_t  <= 1'b0;
        cmp_t    <= 1'b0;
        sign_f   <= 1'b0;
      end else begin
        borrow_t <= borrow_t ^ ev_underflow;
        carry_t  <= carry_t ^ ev_overflow;
        cmp_t    <= cmp_t ^ cmp_edge;
        if (ev_underflow)     sign_f <= 1'b1;
        else if (ev_overflow) sign_f <= 1'b0;
      end
      if (clr_error)                  err_f <= 1'b0;
      else if (ev_noise && quad_mode) err_f <= 1'b1;
    end
  end

  assign flags = {1'b0, idx_f, up_f, err_f, sign_f, cmp_t, carry_t, borrow_t};

  assert_reset_clear_R1: assert property (@(posedge clk) rst |=> flags == 8'h00);

  assert_borrow_toggle_R2: assert property (@(posedge clk) disable iff (rst)
    (ev_underflow && !clr_toggles) |=> flags[0] != $past(flags[0]));

  assert_carry_toggle_R3: assert property (@(posedge clk) disable iff (rst)
    (ev_overflow && !clr_toggles) |=> flags[1] != $past(flags[1]));

  assert_compare_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (!$rose(cmp_equal) && !clr_toggles) |=> $stable(flags[2]));

  assert_sign_set_R5: assert property (@(posedge clk) disable iff (rst)
    (ev_underflow && !clr_toggles) |=> flags[3]);

  assert_error_sticky_R6: assert property (@(posedge clk) disable iff (rst)
    (flags[4] && !clr_error) |=> flags[4]);

  assert_dir_follow_R7: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> flags[5] == $past(dir_up));

  assert_clear_toggles_R8: assert property (@(posedge clk) disable iff (rst)
    clr_toggles |=> flags[3:0] == 4'h0);

  assert_clear_error_R9: assert property (@(posedge clk) disable iff (rst)
    clr_error |=> !flags[4]);

endmodule

// File: tb/test_axis_status_flags.sv
module test_axis_status_flags;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic uf = 0, ov = 0, eq = 0, up = 0, qm = 0, nz = 0, ix = 0, ctg = 0, cer = 0;
  logic [7:0] flags;
  int errors = 0;
  int checks = 0;

  logic m_bt = 0, m_ct = 0, m_cp = 0, m_s = 0, m_e = 0, m_u = 0, m_i = 0, m_prev = 0;

  always #2 clk = ~clk;

  axis_status_flags i_axis_status_flags (
    .clk(clk), .rst(rst), .ev_underflow(uf), .ev_overflow(ov), .cmp_equal(eq),
    .dir_up(up), .quad_mode(qm), .ev_noise(nz), .index_active(ix),
    .clr_toggles(ctg), .clr_error(cer), .flags(flags));

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: flags=%b expected=%b", req, got, exp);
    end
  endtask

  // apply inputs at a falling edge, let one rising edge pass, check at next falling edge
  task automatic cyc(input logic r, input logic u, input logic o, input logic e,
                     input logic d, input logic q, input logic n, input logic x,
                     input logic c1, input logic c2, input string req);
    rst = r; uf = u; ov = o; eq = e; up = d; qm = q; nz = n; ix = x; ctg = c1; cer = c2;
    @(negedge clk);
    if (r) begin
      {m_bt, m_ct, m_cp, m_s, m_e, m_u, m_i} = '0;
    end else begin
      m_u = d; m_i = x;
      if (c1) {m_bt, m_ct, m_cp, m_s} = '0;
      else begin
        if (u) m_bt = ~m_bt;
        if (o) m_ct = ~m_ct;
        if (e && !m_prev) m_cp = ~m_cp;
        if (u) m_s = 1'b1; else if (o) m_s = 1'b0;
      end
      if (c2) m_e = 1'b0; else if (n && q) m_e = 1'b1;
    end
    m_prev = e;
    check(req, flags, {1'b0, m_i, m_u, m_e, m_s, m_cp, m_ct, m_bt});
  endtask

  task automatic t_reset;
    cyc(0,1,1,0,1,1,1,1,0,0,"R1 pre");
    cyc(1,1,0,1,1,1,1,1,0,0,"R1");
    check("R1 zero", flags, 8'h00);
    cyc(0,0,0,1,0,0,0,0,0,0,"R4 eq held through reset");
  endtask

  task automatic t_borrow;
    for (int k = 0; k < 3; k++) cyc(0,1,0,0,0,0,0,0,0,0,"R2");
    cyc(0,0,0,0,0,0,0,0,0,0,"R2 idle");
  endtask

  task automatic t_carry;
    for (int k = 0; k < 3; k++) cyc(0,0,1,0,1,0,0,0,0,0,"R3");
  endtask

  task automatic t_compare;
    cyc(0,0,0,0,0,0,0,0,0,0,"R4 low");
    cyc(0,0,0,1,0,0,0,0,0,0,"R4 rise");
    check("R4 bit", {7'b0, flags[2]}, 8'h01);
    for (int k = 0; k < 4; k++) cyc(0,0,0,1,0,0,0,0,0,0,"R4 held");
    cyc(0,0,0,0,0,0,0,0,0,0,"R4 fall");
    cyc(0,0,0,1,0,0,0,0,0,0,"R4 second rise");
  endtask

  task automatic t_sign;
    cyc(0,1,0,0,0,0,0,0,0,0,"R5 underflow");
    check("R5 set", {7'b0, flags[3]}, 8'h01);
    cyc(0,0,1,0,0,0,0,0,0,0,"R5 overflow");
    check("R5 clr", {7'b0, flags[3]}, 8'h00);
    cyc(0,1,1,0,0,0,0,0,0,0,"R5 both");
    check("R5 both wins", {7'b0, flags[3]}, 8'h01);
  endtask

  task automatic t_error;
    cyc(0,0,0,0,0,0,1,0,0,0,"R6 non-quad ignored");
    check("R6 no set", {7'b0, flags[4]}, 8'h00);
    cyc(0,0,0,0,0,1,1,0,0,0,"R6 set");
    for (int k = 0; k < 3; k++) cyc(0,0,0,0,0,1,0,0,0,0,"R6 sticky");
    check("R6 still", {7'b0, flags[4]}, 8'h01);
  endtask

  task automatic t_levels;
    cyc(0,0,0,0,1,0,0,1,0,0,"R7 up idx");
    check("R7 bits", flags & 8'hE0, 8'h60);
    cyc(0,0,0,0,0,0,0,1,0,0,"R7 down");
    cyc(0,0,0,0,1,0,0,0,0,0,"R7 idx low");
  endtask

  task automatic t_clr_toggles;
    cyc(0,1,0,0,1,1,1,1,0,0,"R8 prep");
    cyc(0,0,0,0,1,1,0,1,0,0,"R8 prep2");
    cyc(0,1,1,1,1,1,0,1,1,0,"R8 collide");
    check("R8 cleared", flags, 8'h70);
  endtask

  task automatic t_clr_error;
    cyc(0,0,1,0,0,1,1,0,0,0,"R9 prep");
    cyc(0,0,0,0,0,1,1,0,0,1,"R9 collide");
    check("R9 cleared", flags & 8'h10, 8'h00);
    cyc(0,0,0,0,0,1,0,0,0,1,"R9 plain");
  endtask

  initial begin
    #100000;
    errors++;
    $display("FAIL watchdog: expired expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    @(negedge clk);
    cyc(1,0,0,0,0,0,0,0,0,0,"R1 initial");
    t_reset();
    t_borrow();
    t_carry();
    t_compare();
    t_sign();
    t_error();
    t_levels();
    t_clr_toggles();
    t_clr_error();
    t_reset();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule